// File: doc/BRIEF.md
# Integer Execute Stage

This block is the integer execute stage of a 32-bit load/store RISC pipeline. Each cycle it may accept one already-decoded operation: an operation code, two register operands, the raw 16-bit immediate, a 5-bit shift amount, the 26-bit jump field and the program counter. One clock later it presents the result word, a taken flag and a control-transfer target.

It covers these operation groups:
- wrapping add and subtract;
- a truncated unsigned multiply;
- bitwise logic with a register operand, a low-half immediate or a high-half immediate;
- set-on-compare operations that write 0 or 1;
- shifts and rotates;
- conditional branches;
- absolute jumps and calls.

There are no condition flags. A branch compares its two register operands directly, and how the immediate is widened depends on the class of the operation.

Top module: `ex_unit`

## Requirements
- R1: ADD (0x00) gives opa+opb, ADDI (0x01) gives opa plus the sign-extended imm16, and SUB (0x02) gives opa-opb. All three wrap modulo 2^32 with no overflow indication.
- R2: MUL (0x03) gives the low 32 bits of the unsigned product opa*opb. MULI (0x04) does the same with the sign-extended imm16 as the second factor.
- R3: AND/OR/XOR/NOR with a register operand use codes 0x05/0x06/0x07/0x08. The immediate forms ANDI/ORI/XORI/NORI use codes 0x09/0x0A/0x0B/0x0C and combine opa with imm16 zero-extended to 32 bits.
- R4: ANDHI (0x0D), ORHI (0x0E) and XORHI (0x0F) combine opa with a word that holds imm16 in bits 31:16 and zeros in bits 15:0.
- R5: The register compares write 1 when the condition holds and 0 otherwise: signed less-than 0x10, unsigned less-than 0x11, equal 0x12, not-equal 0x13, signed less-or-equal 0x14, unsigned less-or-equal 0x15, signed greater-or-equal 0x16, unsigned greater-or-equal 0x17, signed greater-than 0x18, unsigned greater-than 0x19.
- R6: The immediate compares also write 0 or 1. Signed less-than 0x1A, signed greater-or-equal 0x1C, equal 0x1E and not-equal 0x1F use the sign-extended imm16. Unsigned less-than 0x1B and unsigned greater-or-equal 0x1D use the zero-extended imm16.
- R7: The register-amount shifts take their amount from opb[4:0]: SLL 0x20, SRL 0x21, SRA 0x22, ROL 0x23, ROR 0x24. The immediate-amount shifts take it from shamt: SLLI 0x25, SRLI 0x26, SRAI 0x27, ROLI 0x28. Arithmetic right shifts copy the sign bit and logical shifts fill with zero.
- R8: Branches compare opa with opb and set taken when the condition holds: BEQ 0x30, BNE 0x31, BLT 0x32, BLTU 0x33, BGE 0x34, BGEU 0x35, BGT 0x36, BGTU 0x37, BLE 0x38, BLEU 0x39. BR 0x3A is always taken. For every branch the target is pc+4 plus the sign-extended imm16, and the result is 0.
- R9: JMPI (0x3C) and CALL (0x3D) set taken to 1 and form the target from pc[31:28], then imm26, then two zero bits. CALL also writes pc+4 as its result, and JMPI writes 0.
- R10: Every opcode below 0x30 drives taken to 0 and target to 0. An opcode that no requirement defines drives result, taken and target all to 0.
- R11: out_vld, result, taken and target are registered and appear one clock after the cycle in which in_vld was 1. While in_vld is 0, out_vld drops and the other outputs keep their last values. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation present this cycle |
| op | input | 6 | Decoded operation code |
| opa | input | 32 | First register operand |
| opb | input | 32 | Second register operand |
| imm16 | input | 16 | Raw 16-bit immediate |
| shamt | input | 5 | Immediate shift amount |
| pc | input | 32 | Address of the operation |
| imm26 | input | 26 | Jump field |
| out_vld | output | 1 | Outputs carry a new result |
| result | output | 32 | Result word |
| taken | output | 1 | Control transfer taken |
| target | output | 32 | Branch or jump target |

## Verification
The bench applies each vector through a driver, keeps the expected outcome in a queue, and compares it against the outputs once the registered result appears. It targets the places where a wrong extension shows up. An immediate of 0x8000 or 0xFFFF makes a logic immediate or an unsigned compare go wrong if it is sign-extended, and makes ADDI or a signed compare go wrong if it is zero-extended. Operands of 0xFFFFFFFF against 1 separate the signed and unsigned orderings, so swapping them inverts a compare or a branch. Shifts by 0 and 31, arithmetic shifts of negative words and the ROL/ROR pair expose a zero-filling SRA or an off-by-one rotate. A jump from a PC with its top bits set catches a target that drops or misplaces the PC nibble. An idle cycle after a result checks that the outputs hold their last values.

// File: rtl/ex_unit.sv
module ex_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_vld,
  input  logic [5:0]  op,
  input  logic [31:0] opa,
  input  logic [31:0] opb,
  input  logic [15:0] imm16,
  input  logic [4:0]  shamt,
  input  logic [31:0] pc,
  input  logic [25:0] imm26,
  output logic        out_vld,
  output logic [31:0] result,
  output logic        taken,
  output logic [31:0] target
);
  localparam logic [5:0] ADD = 6'h00, ADDI = 6'h01, SUB = 6'h02, MUL = 6'h03, MULI = 6'h04;
  localparam logic [5:0] AND_ = 6'h05, OR_ = 6'h06, XOR_ = 6'h07, NOR_ = 6'h08;
  localparam logic [5:0] ANDI = 6'h09, ORI = 6'h0A, XORI = 6'h0B, NORI = 6'h0C;
  localparam logic [5:0] ANDHI = 6'h0D, ORHI = 6'h0E, XORHI = 6'h0F;
  localparam logic [5:0] CLT = 6'h10, CLTU = 6'h11, CEQ = 6'h12, CNE = 6'h13, CLE = 6'h14;
  localparam logic [5:0] CLEU = 6'h15, CGE = 6'h16, CGEU = 6'h17, CGT = 6'h18, CGTU = 6'h19;
  localparam logic [5:0] CLTI = 6'h1A, CLTUI = 6'h1B, CGEI = 6'h1C, CGEUI = 6'h1D;
  localparam logic [5:0] CEQI = 6'h1E, CNEI = 6'h1F;
  localparam logic [5:0] SLL = 6'h20, SRL = 6'h21, SRA = 6'h22, ROL = 6'h23, ROR = 6'h24;
  localparam logic [5:0] SLLI = 6'h25, SRLI = 6'h26, SRAI = 6'h27, ROLI = 6'h28;
  localparam logic [5:0] BEQ = 6'h30, BNE = 6'h31, BLT = 6'h32, BLTU = 6'h33, BGE = 6'h34;
  localparam logic [5:0] BGEU = 6'h35, BGT = 6'h36, BGTU = 6'h37, BLE = 6'h38, BLEU = 6'h39;
  localparam logic [5:0] BR = 6'h3A, JMPI = 6'h3C, CALL = 6'h3D;

  logic [31:0] sx, zx, hx, cb, pc4;
  logic [31:0] shl, shr, sar, rol_w, ror_w;
  logic [4:0]  amt;
  logic        lt_s, lt_u, eq;
  logic [31:0] res_d, tgt_d;
  logic        tk_d;

  assign sx  = {{16{imm16[15]}}, imm16};
  assign zx  = {16'h0000, imm16};
  assign hx  = {imm16, 16'h0000};
  assign pc4 = pc + 32'd4;

  always_comb begin
    case (op)
      CLTUI, CGEUI:            cb = zx;
      CLTI, CGEI, CEQI, CNEI:  cb = sx;
      default:                 cb = opb;
    endcase
  end

  assign lt_s = $signed(opa) < $signed(cb);
  assign lt_u = opa < cb;
  assign eq   = opa == cb;

  assign amt   = (op >= SLLI) ? shamt : opb[4:0];
  assign shl   = opa << amt;
  assign shr   = opa >> amt;
  assign sar   = $signed(opa) >>> amt;
  assign rol_w = shl | (opa >> (6'd32 - {1'b0, amt}));
  assign ror_w = shr | (opa << (6'd32 - {1'b0, amt}));

  always_comb begin
    res_d = '0;
    tk_d  = 1'b0;
    tgt_d = '0;
    case (op)
      ADD:   res_d = opa + opb;
      ADDI:  res_d = opa + sx;
      SUB:   res_d = opa - opb;
      MUL:   res_d = opa * opb;
      MULI:  res_d = opa * sx;
      AND_:  res_d = opa & opb;
      OR_:   res_d = opa | opb;
      XOR_:  res_d = opa ^ opb;
      NOR_:  res_d = ~(opa | opb);
      ANDI:  res_d = opa & zx;
      ORI:   res_d = opa | zx;
      XORI:  res_d = opa ^ zx;
      NORI:  res_d = ~(opa | zx);
      ANDHI: res_d = opa & hx;
      ORHI:  res_d = opa | hx;
      XORHI: res_d = opa ^ hx;
      CLT, CLTI:          res_d = {31'd0, lt_s};
      CLTU, CLTUI:        res_d = {31'd0, lt_u};
      CEQ, CEQI:          res_d = {31'd0, eq};
      CNE, CNEI:          res_d = {31'd0, !eq};
      CLE:                res_d = {31'd0, lt_s | eq};
      CLEU:               res_d = {31'd0, lt_u | eq};
      CGE, CGEI:          res_d = {31'd0, !lt_s};
      CGEU, CGEUI:        res_d = {31'd0, !lt_u};
      CGT:                res_d = {31'd0, !lt_s & !eq};
      CGTU:               res_d = {31'd0, !lt_u & !eq};
      SLL, SLLI:          res_d = shl;
      SRL, SRLI:          res_d = shr;
      SRA, SRAI:          res_d = sar;
      ROL, ROLI:          res_d = rol_w;
      ROR:                res_d = ror_w;
      BEQ:  begin tk_d = eq;            tgt_d = pc4 + sx; end
      BNE:  begin tk_d = !eq;           tgt_d = pc4 + sx; end
      BLT:  begin tk_d = lt_s;          tgt_d = pc4 + sx; end
      BLTU: begin tk_d = lt_u;          tgt_d = pc4 + sx; end
      BGE:  begin tk_d = !lt_s;         tgt_d = pc4 + sx; end
      BGEU: begin tk_d = !lt_u;         tgt_d = pc4 + sx; end
      BGT:  begin tk_d = !lt_s & !eq;   tgt_d = pc4 + sx; end
      BGTU: begin tk_d = !lt_u & !eq;   tgt_d = pc4 + sx; end
      BLE:  begin tk_d = lt_s | eq;     tgt_d = pc4 + sx; end
      BLEU: begin tk_d = lt_u | eq;     tgt_d = pc4 + sx; end
      BR:   begin tk_d = 1'b1;          tgt_d = pc4 + sx; end
      JMPI: begin tk_d = 1'b1; tgt_d = {pc[31:28], imm26, 2'b00}; end
      CALL: begin tk_d = 1'b1; tgt_d = {pc[31:28], imm26, 2'b00}; res_d = pc4; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      result  <= '0;
      taken   <= 1'b0;
      target  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        result <= res_d;
        taken  <= tk_d;
        target <= tgt_d;
      end
    end
  end
endmodule

module ex_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [5:0]  op,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic [3:0]  pc_hi,
  input logic        out_vld,
  input logic [31:0] result,
  input logic        taken,
  input logic [31:0] target
);
  a_r11_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_vld) |-> ($stable(result) && $stable(taken) && $stable(target)));

  a_r1_sub_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(op) == 6'h02) |-> (result + $past(opb) == $past(opa)));

  a_r4_andhi_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(op) == 6'h0D) |-> (result[15:0] == 16'h0000));

  a_r4_orhi_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(op) == 6'h0E) |-> (result[15:0] == $past(opa[15:0])));

  a_r5_cmp_boolean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(op) >= 6'h10 && $past(op) <= 6'h1F) |-> (result[31:1] == 31'd0));

  a_r9_jump_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && ($past(op) == 6'h3C || $past(op) == 6'h3D))
      |-> (taken && target[1:0] == 2'b00 && target[31:28] == $past(pc_hi)));

  a_r10_no_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(op) < 6'h30) |-> (!taken && target == 32'd0));
endmodule

bind ex_unit ex_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .opa(opa), .opb(opb),
  .pc_hi(pc[31:28]), .out_vld(out_vld), .result(result), .taken(taken), .target(target)
);

// File: tb/tb_ex_unit.sv
module tb_ex_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [5:0]  op = '0;
  logic [31:0] opa = '0, opb = '0, pc = '0;
  logic [15:0] imm16 = '0;
  logic [4:0]  shamt = '0;
  logic [25:0] imm26 = '0;
  logic        out_vld, taken;
  logic [31:0] result, target;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] r;
    logic        t;
    logic [31:0] g;
    logic [23:0] tag;
  } exp_t;
  exp_t q[$];
  exp_t last;

  always #5 clk = ~clk;

  ex_unit dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op), .opa(opa), .opb(opb),
    .imm16(imm16), .shamt(shamt), .pc(pc), .imm26(imm26),
    .out_vld(out_vld), .result(result), .taken(taken), .target(target)
  );

  function automatic exp_t model(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                                 input logic [15:0] i, input logic [4:0] s, input logic [31:0] p,
                                 input logic [25:0] j);
    exp_t e;
    logic signed [31:0] sa, sb, si;
    logic [31:0] zi;
    logic [63:0] dbl;
    logic [4:0] k;
    sa = a; sb = b; si = {{16{i[15]}}, i}; zi = {16'h0, i};
    k = (o >= 6'h25) ? s : b[4:0];
    dbl = {a, a};
    e.r = 0; e.t = 0; e.g = 0; e.tag = "R10";
    if (o <= 6'h02) e.tag = "R1";
    else if (o <= 6'h04) e.tag = "R2";
    else if (o <= 6'h0C) e.tag = "R3";
    else if (o <= 6'h0F) e.tag = "R4";
    else if (o <= 6'h19) e.tag = "R5";
    else if (o <= 6'h1F) e.tag = "R6";
    else if (o <= 6'h28) e.tag = "R7";
    else if (o >= 6'h30 && o <= 6'h3A) e.tag = "R8";
    else if (o == 6'h3C || o == 6'h3D) e.tag = "R9";
    case (o)
      6'h00: e.r = a + b;
      6'h01: e.r = a + si;
      6'h02: e.r = a + ~b + 1;
      6'h03: e.r = 32'((64'(a) * 64'(b)));
      6'h04: e.r = 32'((64'(a) * 64'(unsigned'(si))));
      6'h05: e.r = a & b;
      6'h06: e.r = a | b;
      6'h07: e.r = a ^ b;
      6'h08: e.r = ~a & ~b;
      6'h09: e.r = a & zi;
      6'h0A: e.r = a | zi;
      6'h0B: e.r = a ^ zi;
      6'h0C: e.r = ~a & ~zi;
      6'h0D: e.r = {a[31:16] & i, 16'h0};
      6'h0E: e.r = {a[31:16] | i, a[15:0]};
      6'h0F: e.r = {a[31:16] ^ i, a[15:0]};
      6'h10: e.r = 32'(sa < sb);
      6'h11: e.r = 32'(a < b);
      6'h12: e.r = 32'(a == b);
      6'h13: e.r = 32'(a != b);
      6'h14: e.r = 32'(sa <= sb);
      6'h15: e.r = 32'(a <= b);
      6'h16: e.r = 32'(sa >= sb);
      6'h17: e.r = 32'(a >= b);
      6'h18: e.r = 32'(sa > sb);
      6'h19: e.r = 32'(a > b);
      6'h1A: e.r = 32'(sa < si);
      6'h1B: e.r = 32'(a < zi);
      6'h1C: e.r = 32'(sa >= si);
      6'h1D: e.r = 32'(a >= zi);
      6'h1E: e.r = 32'(a == unsigned'(si));
      6'h1F: e.r = 32'(a != unsigned'(si));
      6'h20, 6'h25: e.r = a << k;
      6'h21, 6'h26: e.r = a >> k;
      6'h22, 6'h27: e.r = 32'(sa >>> k);
      6'h23, 6'h28: e.r = dbl[63 - k -: 32];
      6'h24: e.r = dbl[31 + k -: 32];
      6'h30, 6'h31, 6'h32, 6'h33, 6'h34, 6'h35, 6'h36, 6'h37, 6'h38, 6'h39, 6'h3A: begin
        e.g = p + 32'd4 + si;
        case (o)
          6'h30: e.t = (a == b);
          6'h31: e.t = (a != b);
          6'h32: e.t = (sa < sb);
          6'h33: e.t = (a < b);
          6'h34: e.t = (sa >= sb);
          6'h35: e.t = (a >= b);
          6'h36: e.t = (sa > sb);
          6'h37: e.t = (a > b);
          6'h38: e.t = (sa <= sb);
          6'h39: e.t = (a <= b);
          default: e.t = 1'b1;
        endcase
      end
      6'h3C: begin e.t = 1; e.g = {p[31:28], j, 2'b00}; end
      6'h3D: begin e.t = 1; e.g = {p[31:28], j, 2'b00}; e.r = p + 32'd4; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic apply(input logic [5:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] i, input logic [4:0] s = 5'd0,
                       input logic [31:0] p = 32'h0000_1000, input logic [25:0] j = 26'd0);
    exp_t e;
    e = model(o, a, b, i, s, p, j);
    q.push_back(e);
    last = e;
    in_vld = 1'b1; op = o; opa = a; opb = b; imm16 = i; shamt = s; pc = p; imm26 = j;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_vld) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL R11: result with no pending operation (act vld=1 exp vld=0)");
      end else begin
        e = q.pop_front();
        if (result !== e.r || taken !== e.t || target !== e.g) begin
          fails++;
          $display("FAIL %s: act res=%h tk=%b tgt=%h exp res=%h tk=%b tgt=%h",
                   e.tag, result, taken, target, e.r, e.t, e.g);
        end
      end
    end
  end

  task automatic direct_check(input string tag, input logic [31:0] r, input logic t, input logic [31:0] g, input logic v);
    checks++;
    if (result !== r || taken !== t || target !== g || out_vld !== v) begin
      fails++;
      $display("FAIL %s: act res=%h tk=%b tgt=%h vld=%b exp res=%h tk=%b tgt=%h vld=%b",
               tag, result, taken, target, out_vld, r, t, g, v);
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          fails++;
          $display("FAIL watchdog: act running exp finished");
          $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    direct_check("R11", 32'd0, 1'b0, 32'd0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 wrapping arithmetic
    apply(6'h00, 32'hFFFF_FFFF, 32'd1, 16'h0);
    apply(6'h01, 32'd10, 32'd0, 16'hFFFE);
    apply(6'h02, 32'd0, 32'd1, 16'h0);
    apply(6'h02, 32'h8000_0000, 32'd1, 16'h0);
    // R2 truncated multiply
    apply(6'h03, 32'hFFFF_FFFF, 32'd2, 16'h0);
    apply(6'h03, 32'h0001_0001, 32'h0001_0001, 16'h0);
    apply(6'h04, 32'd3, 32'd0, 16'hFFFF);
    // R3 logic
    apply(6'h05, 32'hF0F0_F0F0, 32'hFF00_FF00, 16'h0);
    apply(6'h06, 32'hF0F0_F0F0, 32'h0F00_000F, 16'h0);
    apply(6'h07, 32'hAAAA_AAAA, 32'hFFFF_0000, 16'h0);
    apply(6'h08, 32'h1234_5678, 32'h0, 16'h0);
    apply(6'h09, 32'hFFFF_FFFF, 32'h0, 16'h8000);
    apply(6'h0A, 32'h1234_0000, 32'h0, 16'hFFFF);
    apply(6'h0B, 32'hFFFF_FFFF, 32'h0, 16'h00FF);
    apply(6'h0C, 32'h0, 32'h0, 16'h8001);
    // R4 high-half immediates
    apply(6'h0D, 32'hFFFF_FFFF, 32'h0, 16'h0F0F);
    apply(6'h0E, 32'h0000_1234, 32'h0, 16'hABCD);
    apply(6'h0F, 32'hFFFF_5555, 32'h0, 16'hFFFF);
    // R5 register compares: -1 vs 1 and equal operands
    for (int c = 6'h10; c <= 6'h19; c++) begin
      apply(6'(c), 32'hFFFF_FFFF, 32'd1, 16'h0);
      apply(6'(c), 32'd7, 32'd7, 16'h0);
    end
    // R6 immediate compares with imm 0xFFFF and 0x0005
    for (int c = 6'h1A; c <= 6'h1F; c++) begin
      apply(6'(c), 32'd5, 32'h0, 16'hFFFF);
      apply(6'(c), 32'hFFFF_FFFF, 32'h0, 16'hFFFF);
      apply(6'(c), 32'd5, 32'h0, 16'h0005);
    end
    // R7 shifts and rotates
    apply(6'h20, 32'h8000_0001, 32'd1, 16'h0);
    apply(6'h21, 32'h8000_0000, 32'd31, 16'h0);
    apply(6'h22, 32'h8000_0000, 32'd4, 16'h0);
    apply(6'h22, 32'h4000_0000, 32'hFFFF_FFE4, 16'h0);
    apply(6'h23, 32'h8000_0001, 32'd0, 16'h0);
    apply(6'h23, 32'h8000_0001, 32'd1, 16'h0);
    apply(6'h24, 32'h8000_0001, 32'd1, 16'h0);
    apply(6'h24, 32'h1234_5678, 32'd31, 16'h0);
    apply(6'h25, 32'h0000_00FF, 32'd0, 16'h0, 5'd28);
    apply(6'h26, 32'hF000_0000, 32'd9, 16'h0, 5'd31);
    apply(6'h27, 32'hF000_0000, 32'd0, 16'h0, 5'd8);
    apply(6'h28, 32'h1234_5678, 32'd0, 16'h0, 5'd4);
    // R8 branches, taken and not taken, forward and backward
    for (int c = 6'h30; c <= 6'h3A; c++) begin
      apply(6'(c), 32'hFFFF_FFFF, 32'd1, 16'hFFF0, 5'd0, 32'h0000_2000);
      apply(6'(c), 32'd3, 32'd3, 16'h0010, 5'd0, 32'h0000_2000);
    end
    // R9 jumps and calls
    apply(6'h3C, 32'h0, 32'h0, 16'h0, 5'd0, 32'hA000_0010, 26'h3FF_FFFF);
    apply(6'h3D, 32'h0, 32'h0, 16'h0, 5'd0, 32'h5FFF_FFFC, 26'h000_1234);
    // R10 undefined opcodes
    apply(6'h3F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF);
    apply(6'h2C, 32'h1234_5678, 32'd1, 16'h1111);

    // R11 hold: idle cycles with changed inputs must not disturb outputs
    apply(6'h00, 32'd5, 32'd6, 16'h0);
    op = 6'h02; opa = 32'hDEAD_BEEF; opb = 32'd99; pc = 32'hF000_0000;
    @(negedge clk);
    @(negedge clk);
    direct_check("R11", last.r, last.t, last.g, 1'b0);
    apply(6'h3A, 32'h0, 32'h0, 16'h0004, 5'd0, 32'h0000_0100);
    op = 6'h00; imm16 = 16'h7777;
    @(negedge clk);
    direct_check("R11", last.r, last.t, last.g, 1'b0);

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11: act pending=%0d exp pending=0", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule